// File: doc/BRIEF.md
# Indexed Indirect Address Generator

This block produces effective operand addresses for a small controller CPU. It keeps a bank of sixteen 32-bit index registers. Each operand request names one register and one of five addressing modes: the register as is, the register plus a signed 12-bit constant, the register plus a signed 16-bit data value, the register followed by a post-increment, or a pre-decrement followed by use of the register. The effective address appears one clock after the request. The execution stage signals the end of each instruction with a strobe, and it can report a fault at any time during the instruction.

Increments and decrements are not written to the bank straight away. They are held per register until the end-of-instruction strobe. Later requests in the same instruction see the held value. At the end of the instruction all held updates are written together, unless the instruction faulted, in which case every held update is dropped. A strap input selects the reduced-memory build. On that build any effective address inside the window 10000 to 31999 raises an illegal-access flag, and that flag counts as a fault for the instruction.

Top module: `idx_addr_gen`

## Requirements
- R1: Mode code 0 (plain) returns the selected register's content unchanged as the address. Codes 5, 6 and 7 behave exactly like code 0.
- R2: Mode code 1 sign-extends the 12-bit constant (range -2048 to 2047) and adds it modulo 2^32 to the selected register's content. The register is left unchanged.
- R3: Mode code 2 sign-extends the 16-bit data value and adds it modulo 2^32 to the selected register's content. The register is left unchanged.
- R4: Mode code 3 returns the register's current content as the address and schedules that content plus the step. The step is 1 when req_step2=0 and 2 when req_step2=1.
- R5: Mode code 4 subtracts the step (1 or 2, chosen the same way) modulo 2^32, returns the result as the address and schedules it as the register's new value.
- R6: Scheduled updates are written to the bank only at an instr_end cycle. A request in the same cycle as instr_end belongs to the instruction that is ending. Later requests within one instruction use the scheduled value. In the cycle after a committing instr_end, wb_mask has bit i set for each register i that was written; at all other times wb_mask is zero.
- R7: If exec_err is high in any cycle of an instruction, up to and including its instr_end cycle, all scheduled updates of that instruction are discarded and wb_mask stays zero.
- R8: When reduced_mem=1 and a request's effective address lies in the inclusive range 10000 to 31999, illegal_out is high with that result. Addresses 9999 and 32000 do not raise it. An illegal access aborts the instruction's updates as R7 describes.
- R9: addr_out, illegal_out and addr_valid are registered. addr_valid is high exactly in the cycle after a cycle with req_valid high.
- R10: Synchronous reset clears all index registers, any scheduled updates, any pending fault, addr_out, addr_valid, illegal_out and wb_mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Operand address request this cycle |
| req_mode | input | 3 | Addressing mode code (0 to 4; 5 to 7 act as 0) |
| req_sel | input | 4 | Index register number |
| req_step2 | input | 1 | Step size for modes 3 and 4: 0 gives 1, 1 gives 2 |
| req_const | input | 12 | Signed constant offset for mode 1 |
| req_dreg | input | 16 | Signed data-register value for mode 2 |
| exec_err | input | 1 | Execution fault in the current instruction |
| instr_end | input | 1 | Last cycle of the current instruction |
| reduced_mem | input | 1 | Strap selecting the reduced-memory build |
| addr_out | output | 32 | Effective address |
| addr_valid | output | 1 | addr_out holds a fresh result |
| illegal_out | output | 1 | Effective address falls in the forbidden window |
| wb_mask | output | 16 | Registers written by the last commit |

## Verification
A request's address, illegal flag and valid pulse all come from one register stage, so they are due one clock after the request edge. The bench drives inputs on the falling edge and reads those outputs on the next falling edge. wb_mask is registered at the instr_end edge and is read in that same half cycle. A committed register value shows up in the result of a plain request issued in the following cycle, one clock later. Multi-cycle instructions exercise the ordering claims: a fault or illegal access arriving before the end cycle, an end cycle with no request, and a reset that falls between a scheduled update and its commit.

// File: rtl/idx_pkg.sv
package idx_pkg;
  localparam int unsigned IDX_COUNT   = 16;
  localparam int unsigned IDX_AW      = 32;
  localparam int unsigned IDX_CW      = 12;
  localparam int unsigned IDX_DW      = 16;
  localparam int unsigned IDX_WIN_LO  = 10000;
  localparam int unsigned IDX_WIN_HI  = 31999;

  typedef enum logic [2:0] {
    M_PLAIN   = 3'd0,
    M_CONST   = 3'd1,
    M_DREG    = 3'd2,
    M_POSTINC = 3'd3,
    M_PREDEC  = 3'd4
  } ea_mode_e;
endpackage

// File: rtl/idx_ea_calc.sv
module idx_ea_calc
  import idx_pkg::*;
#(
  parameter int unsigned AW = IDX_AW,
  parameter int unsigned CW = IDX_CW,
  parameter int unsigned DW = IDX_DW
) (
  input  logic [AW-1:0] base,
  input  logic [2:0]    mode,
  input  logic          step2,
  input  logic [CW-1:0] cst,
  input  logic [DW-1:0] dval,
  output logic [AW-1:0] ea,
  output logic          upd_en,
  output logic [AW-1:0] upd_val
);
  function automatic logic [AW-1:0] widen_c(input logic [CW-1:0] c);
    return {{(AW-CW){c[CW-1]}}, c};
  endfunction

  function automatic logic [AW-1:0] widen_d(input logic [DW-1:0] d);
    return {{(AW-DW){d[DW-1]}}, d};
  endfunction

  function automatic logic [AW-1:0] step_of(input logic two);
    return two ? AW'(2) : AW'(1);
  endfunction

  logic [AW-1:0] step_amt;
  logic [AW-1:0] dec_val;

  assign step_amt = step_of(step2);
  assign dec_val  = base - step_amt;

  always_comb begin
    ea      = base;
    upd_en  = 1'b0;
    upd_val = base;
    case (mode)
      M_CONST: ea = base + widen_c(cst);
      M_DREG:  ea = base + widen_d(dval);
      M_POSTINC: begin
        ea      = base;
        upd_en  = 1'b1;
        upd_val = base + step_amt;
      end
      M_PREDEC: begin
        ea      = dec_val;
        upd_en  = 1'b1;
        upd_val = dec_val;
      end
      default: ea = base;
    endcase
  end
endmodule

// File: rtl/idx_pend.sv
module idx_pend #(
  parameter int unsigned N  = 16,
  parameter int unsigned AW = 32,
  localparam int unsigned SW = $clog2(N)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [N-1:0][AW-1:0] ir_q,
  input  logic                 stage_en,
  input  logic [SW-1:0]        stage_sel,
  input  logic [AW-1:0]        stage_val,
  input  logic                 fault_now,
  input  logic                 instr_end,
  output logic [N-1:0][AW-1:0] view,
  output logic                 commit_en,
  output logic [N-1:0]         commit_mask,
  output logic [N-1:0][AW-1:0] commit_val
);
  logic [N-1:0]          pend_vld;
  logic [N-1:0][AW-1:0]  pend_val;
  logic                  fault_q;
  logic [N-1:0]          mrg_vld;
  logic [N-1:0][AW-1:0]  mrg_val;
  logic                  abort_now;

  for (genvar i = 0; i < N; i++) begin : g_slot
    logic hit;
    assign hit        = stage_en && (stage_sel == SW'(i));
    assign view[i]    = pend_vld[i] ? pend_val[i] : ir_q[i];
    assign mrg_vld[i] = pend_vld[i] | hit;
    assign mrg_val[i] = hit ? stage_val : pend_val[i];
  end

  assign abort_now   = fault_q | fault_now;
  assign commit_en   = instr_end & ~abort_now;
  assign commit_mask = commit_en ? mrg_vld : '0;
  assign commit_val  = mrg_val;

  always_ff @(posedge clk) begin
    if (rst || instr_end) begin
      pend_vld <= '0;
      pend_val <= '0;
      fault_q  <= 1'b0;
    end else begin
      pend_vld <= mrg_vld;
      pend_val <= mrg_val;
      fault_q  <= abort_now;
    end
  end

  // R6
  pend_clear_chk: assert property (@(posedge clk) disable iff (rst)
    instr_end |=> (pend_vld == '0));

  // R7
  fault_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (fault_now && !instr_end) |=> fault_q);
endmodule

// File: rtl/idx_bank.sv
module idx_bank #(
  parameter int unsigned N  = 16,
  parameter int unsigned AW = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 commit_en,
  input  logic [N-1:0]         commit_mask,
  input  logic [N-1:0][AW-1:0] commit_val,
  output logic [N-1:0][AW-1:0] ir_q
);
  for (genvar i = 0; i < N; i++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst)
        ir_q[i] <= '0;
      else if (commit_mask[i])
        ir_q[i] <= commit_val[i];
    end
  end

  // R6
  bank_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !commit_en |=> $stable(ir_q));

  // R10
  bank_reset_chk: assert property (@(posedge clk)
    $past(rst) |-> (ir_q == '0));
endmodule

// File: rtl/idx_addr_gen.sv
module idx_addr_gen
  import idx_pkg::*;
#(
  parameter int unsigned N      = IDX_COUNT,
  parameter int unsigned AW     = IDX_AW,
  parameter int unsigned CW     = IDX_CW,
  parameter int unsigned DW     = IDX_DW,
  parameter int unsigned WIN_LO = IDX_WIN_LO,
  parameter int unsigned WIN_HI = IDX_WIN_HI,
  localparam int unsigned SW    = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic [2:0]    req_mode,
  input  logic [SW-1:0] req_sel,
  input  logic          req_step2,
  input  logic [CW-1:0] req_const,
  input  logic [DW-1:0] req_dreg,
  input  logic          exec_err,
  input  logic          instr_end,
  input  logic          reduced_mem,
  output logic [AW-1:0] addr_out,
  output logic          addr_valid,
  output logic          illegal_out,
  output logic [N-1:0]  wb_mask
);
  function automatic logic in_window(input logic [AW-1:0] a);
    return (a >= AW'(WIN_LO)) && (a <= AW'(WIN_HI));
  endfunction

  logic [N-1:0][AW-1:0] ir_q;
  logic [N-1:0][AW-1:0] view;
  logic [AW-1:0]        base;
  logic [AW-1:0]        ea;
  logic                 upd_en;
  logic [AW-1:0]        upd_val;
  logic                 ill_now;
  logic                 fault_now;
  logic                 commit_en;
  logic [N-1:0]         commit_mask;
  logic [N-1:0][AW-1:0] commit_val;

  assign base      = view[req_sel];
  assign ill_now   = req_valid && reduced_mem && in_window(ea);
  assign fault_now = exec_err | ill_now;

  idx_ea_calc #(.AW(AW), .CW(CW), .DW(DW)) u_calc (
    .base    (base),
    .mode    (req_mode),
    .step2   (req_step2),
    .cst     (req_const),
    .dval    (req_dreg),
    .ea      (ea),
    .upd_en  (upd_en),
    .upd_val (upd_val)
  );

  idx_pend #(.N(N), .AW(AW)) u_pend (
    .clk         (clk),
    .rst         (rst),
    .ir_q        (ir_q),
    .stage_en    (req_valid & upd_en),
    .stage_sel   (req_sel),
    .stage_val   (upd_val),
    .fault_now   (fault_now),
    .instr_end   (instr_end),
    .view        (view),
    .commit_en   (commit_en),
    .commit_mask (commit_mask),
    .commit_val  (commit_val)
  );

  idx_bank #(.N(N), .AW(AW)) u_bank (
    .clk         (clk),
    .rst         (rst),
    .commit_en   (commit_en),
    .commit_mask (commit_mask),
    .commit_val  (commit_val),
    .ir_q        (ir_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_out    <= '0;
      addr_valid  <= 1'b0;
      illegal_out <= 1'b0;
      wb_mask     <= '0;
    end else begin
      addr_valid  <= req_valid;
      illegal_out <= ill_now;
      wb_mask     <= commit_mask;
      if (req_valid)
        addr_out <= ea;
    end
  end

  // R9
  valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> addr_valid);

  // R9
  valid_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !addr_valid);

  // R8
  ill_strap_chk: assert property (@(posedge clk) disable iff (rst)
    illegal_out |-> ($past(reduced_mem) && addr_valid));

  // R6
  wb_end_chk: assert property (@(posedge clk) disable iff (rst)
    (wb_mask != '0) |-> $past(instr_end));

  // R7
  wb_abort_chk: assert property (@(posedge clk) disable iff (rst)
    (instr_end && exec_err) |=> (wb_mask == '0));

  // R10
  reset_clear_chk: assert property (@(posedge clk)
    $past(rst) |-> (!addr_valid && !illegal_out && wb_mask == '0));
endmodule

// File: tb/idx_addr_gen_test.sv
`timescale 1ns/1ps
module idx_addr_gen_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [2:0]  req_mode = '0;
  logic [3:0]  req_sel = '0;
  logic        req_step2 = 1'b0;
  logic [11:0] req_const = '0;
  logic [15:0] req_dreg = '0;
  logic        exec_err = 1'b0;
  logic        instr_end = 1'b0;
  logic        reduced_mem = 1'b0;
  logic [31:0] addr_out;
  logic        addr_valid;
  logic        illegal_out;
  logic [15:0] wb_mask;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  idx_addr_gen uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_mode(req_mode),
    .req_sel(req_sel), .req_step2(req_step2), .req_const(req_const),
    .req_dreg(req_dreg), .exec_err(exec_err), .instr_end(instr_end),
    .reduced_mem(reduced_mem), .addr_out(addr_out), .addr_valid(addr_valid),
    .illegal_out(illegal_out), .wb_mask(wb_mask)
  );

  typedef struct packed {
    logic [2:0]  mode;
    logic [3:0]  sel;
    logic        st2;
    logic [11:0] cst;
    logic [15:0] dr;
    logic        red;
    logic        err;
    logic [31:0] ea;
    logic        ill;
  } vec_t;

  localparam int NV = 24;
  localparam vec_t VECS [NV] = '{
    '{3'd0, 4'd0,  1'b0, 12'h000, 16'h0000, 1'b0, 1'b0, 32'h0000_0000, 1'b0},
    '{3'd1, 4'd0,  1'b0, 12'h005, 16'h0000, 1'b0, 1'b0, 32'h0000_0005, 1'b0},
    '{3'd1, 4'd1,  1'b0, 12'h800, 16'h0000, 1'b0, 1'b0, 32'hFFFF_F800, 1'b0},
    '{3'd1, 4'd2,  1'b0, 12'h7FF, 16'h0000, 1'b0, 1'b0, 32'h0000_07FF, 1'b0},
    '{3'd2, 4'd3,  1'b0, 12'h000, 16'd10000, 1'b0, 1'b0, 32'd10000,    1'b0},
    '{3'd2, 4'd3,  1'b0, 12'h000, 16'd10000, 1'b1, 1'b0, 32'd10000,    1'b1},
    '{3'd2, 4'd3,  1'b0, 12'h000, 16'd31999, 1'b1, 1'b0, 32'd31999,    1'b1},
    '{3'd2, 4'd3,  1'b0, 12'h000, 16'd32000, 1'b1, 1'b0, 32'd32000,    1'b0},
    '{3'd2, 4'd3,  1'b0, 12'h000, 16'd9999,  1'b1, 1'b0, 32'd9999,     1'b0},
    '{3'd2, 4'd3,  1'b0, 12'h000, 16'hFFFF, 1'b0, 1'b0, 32'hFFFF_FFFF, 1'b0},
    '{3'd3, 4'd4,  1'b0, 12'h000, 16'h0000, 1'b0, 1'b0, 32'h0000_0000, 1'b0},
    '{3'd3, 4'd4,  1'b1, 12'h000, 16'h0000, 1'b0, 1'b0, 32'h0000_0001, 1'b0},
    '{3'd0, 4'd4,  1'b0, 12'h000, 16'h0000, 1'b0, 1'b0, 32'h0000_0003, 1'b0},
    '{3'd4, 4'd5,  1'b0, 12'h000, 16'h0000, 1'b0, 1'b0, 32'hFFFF_FFFF, 1'b0},
    '{3'd4, 4'd5,  1'b1, 12'h000, 16'h0000, 1'b0, 1'b0, 32'hFFFF_FFFD, 1'b0},
    '{3'd0, 4'd5,  1'b0, 12'h000, 16'h0000, 1'b0, 1'b0, 32'hFFFF_FFFD, 1'b0},
    '{3'd3, 4'd6,  1'b1, 12'h000, 16'h0000, 1'b0, 1'b1, 32'h0000_0000, 1'b0},
    '{3'd0, 4'd6,  1'b0, 12'h000, 16'h0000, 1'b0, 1'b0, 32'h0000_0000, 1'b0},
    '{3'd1, 4'd4,  1'b0, 12'hFFC, 16'h0000, 1'b0, 1'b0, 32'hFFFF_FFFF, 1'b0},
    '{3'd0, 4'd4,  1'b0, 12'h000, 16'h0000, 1'b0, 1'b0, 32'h0000_0003, 1'b0},
    '{3'd7, 4'd4,  1'b0, 12'h000, 16'h0000, 1'b0, 1'b0, 32'h0000_0003, 1'b0},
    '{3'd5, 4'd4,  1'b0, 12'h000, 16'h0000, 1'b0, 1'b0, 32'h0000_0003, 1'b0},
    '{3'd2, 4'd4,  1'b0, 12'h000, 16'h8000, 1'b0, 1'b0, 32'hFFFF_8003, 1'b0},
    '{3'd0, 4'd15, 1'b0, 12'h000, 16'h0000, 1'b0, 1'b0, 32'h0000_0000, 1'b0}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Drive one cycle of inputs at a falling edge; return at the next falling edge,
  // by which time the registered results of this cycle are visible.
  task automatic cyc(input logic v, input logic [2:0] m, input logic [3:0] s,
                     input logic st2, input logic [11:0] c, input logic [15:0] d,
                     input logic red, input logic err, input logic fin);
    req_valid = v; req_mode = m; req_sel = s; req_step2 = st2;
    req_const = c; req_dreg = d; reduced_mem = red; exec_err = err;
    instr_end = fin;
    @(negedge clk);
  endtask

  task automatic idle();
    cyc(1'b0, 3'd0, 4'd0, 1'b0, 12'h0, 16'h0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic plain_read(input logic [3:0] s, input logic [31:0] exp, input string tag);
    cyc(1'b1, 3'd0, s, 1'b0, 12'h0, 16'h0, 1'b0, 1'b0, 1'b1);
    chk(tag, addr_out, exp);
  endtask

  function automatic string mode_tag(input logic [2:0] m);
    case (m)
      3'd1: return "R2";
      3'd2: return "R3";
      3'd3: return "R4";
      3'd4: return "R5";
      default: return "R1";
    endcase
  endfunction

  initial begin
    @(negedge clk);
    @(negedge clk);
    // R10: outputs cleared while reset is held
    chk("R10 addr_valid in reset", {31'b0, addr_valid}, 32'd0);
    chk("R10 wb_mask in reset", {16'b0, wb_mask}, 32'd0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      vec_t v;
      logic [15:0] exp_wb;
      v = VECS[i];
      cyc(1'b1, v.mode, v.sel, v.st2, v.cst, v.dr, v.red, v.err, 1'b1);
      exp_wb = ((v.mode == 3'd3 || v.mode == 3'd4) && !v.err && !v.ill)
               ? (16'd1 << v.sel) : 16'd0;
      chk($sformatf("%s vec%0d addr", mode_tag(v.mode), i), addr_out, v.ea);
      chk($sformatf("R8 vec%0d illegal", i), {31'b0, illegal_out}, {31'b0, v.ill});
      chk($sformatf("R9 vec%0d valid", i), {31'b0, addr_valid}, 32'd1);
      chk($sformatf("%s vec%0d wb_mask", v.err ? "R7" : "R6", i), {16'b0, wb_mask}, {16'b0, exp_wb});
    end

    // R9: no request gives no valid pulse
    idle();
    chk("R9 idle valid", {31'b0, addr_valid}, 32'd0);

    // R6: two post-increments in one instruction chain through the held value
    cyc(1'b1, 3'd3, 4'd8, 1'b0, 12'h0, 16'h0, 1'b0, 1'b0, 1'b0);
    chk("R6 first inc addr", addr_out, 32'd0);
    chk("R6 no wb before end", {16'b0, wb_mask}, 32'd0);
    cyc(1'b1, 3'd3, 4'd8, 1'b0, 12'h0, 16'h0, 1'b0, 1'b0, 1'b1);
    chk("R6 second inc sees held value", addr_out, 32'd1);
    chk("R6 wb_mask at commit", {16'b0, wb_mask}, 32'h0000_0100);
    plain_read(4'd8, 32'd2, "R6 committed value");

    // R6: end cycle without a request commits earlier held update
    cyc(1'b1, 3'd4, 4'd10, 1'b1, 12'h0, 16'h0, 1'b0, 1'b0, 1'b0);
    chk("R5 predec addr", addr_out, 32'hFFFF_FFFE);
    cyc(1'b0, 3'd0, 4'd0, 1'b0, 12'h0, 16'h0, 1'b0, 1'b0, 1'b1);
    chk("R6 bare end wb_mask", {16'b0, wb_mask}, 32'h0000_0400);
    plain_read(4'd10, 32'hFFFF_FFFE, "R6 bare end value");

    // R8: illegal access earlier in the instruction aborts a later increment
    cyc(1'b1, 3'd2, 4'd3, 1'b0, 12'h0, 16'd20000, 1'b1, 1'b0, 1'b0);
    chk("R8 mid illegal flag", {31'b0, illegal_out}, 32'd1);
    cyc(1'b1, 3'd3, 4'd7, 1'b1, 12'h0, 16'h0, 1'b0, 1'b0, 1'b1);
    chk("R8 abort wb_mask", {16'b0, wb_mask}, 32'd0);
    plain_read(4'd7, 32'd0, "R8 aborted register unchanged");

    // R7: fault in a middle cycle discards the held update at end
    cyc(1'b1, 3'd3, 4'd9, 1'b0, 12'h0, 16'h0, 1'b0, 1'b0, 1'b0);
    cyc(1'b0, 3'd0, 4'd0, 1'b0, 12'h0, 16'h0, 1'b0, 1'b1, 1'b0);
    cyc(1'b0, 3'd0, 4'd0, 1'b0, 12'h0, 16'h0, 1'b0, 1'b0, 1'b1);
    chk("R7 sticky fault wb_mask", {16'b0, wb_mask}, 32'd0);
    plain_read(4'd9, 32'd0, "R7 register unchanged");

    // R10: reset between scheduling and commit drops the update and clears the bank
    cyc(1'b1, 3'd3, 4'd11, 1'b0, 12'h0, 16'h0, 1'b0, 1'b0, 1'b0);
    rst = 1'b1;
    idle();
    chk("R10 valid after reset", {31'b0, addr_valid}, 32'd0);
    chk("R10 addr after reset", addr_out, 32'd0);
    rst = 1'b0;
    cyc(1'b0, 3'd0, 4'd0, 1'b0, 12'h0, 16'h0, 1'b0, 1'b0, 1'b1);
    chk("R10 pending cleared", {16'b0, wb_mask}, 32'd0);
    plain_read(4'd11, 32'd0, "R10 held update dropped");
    plain_read(4'd4, 32'd0, "R10 bank cleared");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule